// File: doc/BRIEF.md
# Port Bypass Control and Signal-Detect Register

This block is one byte-wide control and status register for a single port-bypass channel on a backplane controller. It works alongside a high-speed port bypass circuit. One pin carries the force-bypass level to that circuit, and a second pin brings back the circuit's signal-detect level. Software reaches the register over a simple byte bus, which carries an address, write data, a write strobe, a read strobe and combinational read data.

The block cleans up both pin levels before anything uses them. Each level passes through a two-flop synchronizer and then a glitch filter, and register reads always return these filtered levels. Software can therefore read the externally strapped default of the force-bypass pin before it takes control of that pin.

Once the channel is enabled, the block drives the force-bypass pin and protects the link. A loss of signal clears force-bypass in hardware, which drops the port into Bypass. Any edge of the filtered signal-detect level can raise an active-low interrupt. That interrupt loads the register's own address into a source register, and reading the source register clears both the interrupt and the source register.

Top module: `bypass_ctl_reg`

## Requirements
- R1: After reset the enable and interrupt-enable bits are 0, `fb_oe` is 0, `irq_n` is 1 and the source register reads 0x00. Reading the control register at 0x2E then returns bit 1 equal to the filtered force-bypass pin level and bit 0 equal to the filtered signal-detect level, so it reads 0x03 with both pins high and bit 1 reads 0 when the pin is strapped low.
- R2: A write to 0x2E stores bit 7 (channel enable) and bit 6 (interrupt enable), and a read of 0x2E returns them in the same positions. Bits 5:2 always read 0 and ignore writes. Any address other than 0x2E and the source address 0x30 reads 0x00.
- R3: A new pin level shows in the register read data exactly FILT_LEN+2 clocks after it reaches the pin. A pulse shorter than FILT_LEN clocks never shows, and a pulse of FILT_LEN clocks or longer does show.
- R4: `fb_oe` equals the enable bit and `fb_out` carries the force-bypass bit, where 1 means Normal and 0 means Bypass. While enable is 0, signal-detect edges raise no interrupt.
- R5: While enable is 1 and the filtered signal-detect is 0, the force-bypass bit is cleared. `fb_out` falls FILT_LEN+3 clocks after the signal-detect pin falls, which is 70 ns at a 10 ns clock with FILT_LEN=4 and within the 400 ns bound.
- R6: While enable is 1 and the filtered signal-detect is 0, a write of 1 to bit 1 leaves force-bypass at 0. While the filtered signal-detect is 1, a write to bit 1 takes effect on the next clock.
- R7: With enable and interrupt enable both 1, a rising or falling edge of the filtered signal-detect drives `irq_n` low one clock later, and the source register at 0x30 then reads 0x2E. With interrupt enable 0, no interrupt is raised.
- R8: `irq_n` stays low until the host reads address 0x30 with `bus_re` set. On the clock after that read, `irq_n` is 1 and the source register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (a read of the source register clears it) |
| bus_rdata | output | 8 | Combinational read data |
| sd_pin | input | 1 | Raw signal-detect pin level |
| fb_pin | input | 1 | Level seen on the force-bypass pin |
| fb_out | output | 1 | Force-bypass drive value (1 Normal, 0 Bypass) |
| fb_oe | output | 1 | Force-bypass pin output enable, overriding other pin configuration |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A corrupt filter counter or synchronizer stage shows up as the filtered level appearing one clock early or late, or as a short glitch leaking into read bit 0. The bench catches this by sampling on every clock around the FILT_LEN+2 boundary and by sweeping pulse lengths through FILT_LEN. A force-bypass bit that is stuck or not cleared leaves `fb_out` high on the clock after the FILT_LEN+3 boundary. A missed edge or a clear that does not happen shows on `irq_n` within one clock, and the source register read exposes a wrong code at once.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    localparam int BYTE_W = 8;

    // bit positions in the control register
    localparam int BIT_EN = 7;
    localparam int BIT_IE = 6;
    localparam int BIT_FB = 1;
    localparam int BIT_SD = 0;

    typedef struct packed {
        logic en;
        logic ie;
        logic fb;
    } ctl_t;

    typedef struct packed {
        logic fb_lvl;
        logic sd_lvl;
    } pins_t;

    function automatic logic [BYTE_W-1:0] pack_ctl(ctl_t c, pins_t p);
        logic [BYTE_W-1:0] v;
        v = '0;
        v[BIT_EN] = c.en;
        v[BIT_IE] = c.ie;
        v[BIT_FB] = p.fb_lvl;
        v[BIT_SD] = p.sd_lvl;
        return v;
    endfunction

endpackage

// File: rtl/bpc_pin_filter.sv
module bpc_pin_filter #(
    parameter int   FILT_LEN = 4,
    parameter logic RST_LVL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic lvl
);
    localparam int CW = $clog2(FILT_LEN) + 1;

    logic          s1, s2, filt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= RST_LVL;
            s2   <= RST_LVL;
            filt <= RST_LVL;
            cnt  <= '0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            if (s2 != filt) begin
                if (cnt == CW'(FILT_LEN - 1)) begin
                    filt <= s2;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    assign lvl = filt;

    AST_FILT_AGREES: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt) |-> filt == $past(s2)); // R3

endmodule

// File: rtl/bpc_irq_src.sv
module bpc_irq_src #(
    parameter logic [7:0] SRC_CODE = 8'h2E,
    parameter logic       RST_LVL  = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       lvl,
    input  logic       clr,
    output logic       irq_n,
    output logic [7:0] src
);
    logic prev, pend, hit;

    assign hit = arm && (lvl != prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= RST_LVL;
            pend <= 1'b0;
            src  <= '0;
        end else begin
            prev <= lvl;
            if (hit) begin
                pend <= 1'b1;
                src  <= SRC_CODE;
            end else if (clr) begin
                pend <= 1'b0;
                src  <= '0;
            end
        end
    end

    assign irq_n = ~pend;

    AST_IRQ_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (arm && !$stable(lvl)) |=> !irq_n); // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !clr) |=> !irq_n); // R8
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && clr && !(arm && !$stable(lvl))) |=> (irq_n && src == 8'h00)); // R8
    AST_SRC_CODE: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> src == SRC_CODE); // R7

endmodule

// File: rtl/bypass_ctl_reg.sv
module bypass_ctl_reg
    import bpc_pkg::*;
#(
    parameter logic [7:0] REG_ADDR = 8'h2E,
    parameter logic [7:0] SRC_ADDR = 8'h30,
    parameter int         FILT_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_we,
    input  logic       bus_re,
    output logic [7:0] bus_rdata,
    input  logic       sd_pin,
    input  logic       fb_pin,
    output logic       fb_out,
    output logic       fb_oe,
    output logic       irq_n
);
    ctl_t       ctl_q, ctl_d;
    pins_t      filt;
    logic [1:0] raw, lvl;
    logic [7:0] src;
    logic       wr_hit, src_rd;

    assign raw = {fb_pin, sd_pin};

    for (genvar g = 0; g < 2; g++) begin : g_pin
        bpc_pin_filter #(.FILT_LEN(FILT_LEN), .RST_LVL(1'b1)) i_filt (
            .clk (clk),
            .rst (rst),
            .pin (raw[g]),
            .lvl (lvl[g])
        );
    end

    assign filt.fb_lvl = lvl[1];
    assign filt.sd_lvl = lvl[0];

    assign wr_hit = bus_we && (bus_addr == REG_ADDR);
    assign src_rd = bus_re && (bus_addr == SRC_ADDR);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_hit) begin
            ctl_d.en = bus_wdata[BIT_EN];
            ctl_d.ie = bus_wdata[BIT_IE];
            ctl_d.fb = bus_wdata[BIT_FB];
        end
        // signal loss forces Bypass and blocks host attempts to leave it
        if (ctl_q.en && !filt.sd_lvl)
            ctl_d.fb = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.en <= 1'b0;
            ctl_q.ie <= 1'b0;
            ctl_q.fb <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bpc_irq_src #(.SRC_CODE(REG_ADDR), .RST_LVL(1'b1)) i_irq (
        .clk   (clk),
        .rst   (rst),
        .arm   (ctl_q.en && ctl_q.ie),
        .lvl   (filt.sd_lvl),
        .clr   (src_rd),
        .irq_n (irq_n),
        .src   (src)
    );

    always_comb begin
        if (bus_addr == REG_ADDR)      bus_rdata = pack_ctl(ctl_q, filt);
        else if (bus_addr == SRC_ADDR) bus_rdata = src;
        else                           bus_rdata = '0;
    end

    assign fb_oe  = ctl_q.en;
    assign fb_out = ctl_q.fb;

    AST_FB_CLEARS_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
        (fb_oe && !filt.sd_lvl) |=> !fb_out); // R5
    AST_FB_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && filt.sd_lvl) |=> fb_out == $past(bus_wdata[BIT_FB])); // R6
    AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (irq_n && !fb_oe) |=> irq_n); // R4

endmodule

// File: tb/test_bypass_ctl_reg.sv
module test_bypass_ctl_reg;
    localparam int         CLK_P = 10;
    localparam int         N     = 4;
    localparam logic [7:0] RA    = 8'h2E;
    localparam logic [7:0] SA    = 8'h30;

    logic       clk = 1'b0, rst = 1'b1;
    logic [7:0] bus_addr = RA, bus_wdata = '0, bus_rdata;
    logic       bus_we = 1'b0, bus_re = 1'b0;
    logic       sd_pin = 1'b1, strap = 1'b1, fb_pin, fb_out, fb_oe, irq_n;
    int         checks = 0, fails = 0;
    logic [7:0] rv;

    assign fb_pin = fb_oe ? fb_out : strap;

    always #(CLK_P/2) clk = ~clk;

    bypass_ctl_reg #(.REG_ADDR(RA), .SRC_ADDR(SA), .FILT_LEN(N)) i_bypass_ctl_reg (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .sd_pin(sd_pin), .fb_pin(fb_pin), .fb_out(fb_out), .fb_oe(fb_oe), .irq_n(irq_n)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] v);
        @(negedge clk);
        bus_addr = RA; bus_wdata = v; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_re = 1'b0; bus_addr = RA;
    endtask

    task automatic idle(int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst = 1'b0;
        idle(N + 3);
        // R1 reset state
        chk("R1 ctl", bus_rdata, 8'h03);
        chk("R1 oe", {7'b0, fb_oe}, 8'h00);
        chk("R1 irq", {7'b0, irq_n}, 8'h01);
        rd(SA, rv); chk("R1 src", rv, 8'h00);

        // R2/R4 sweep of every write value, pins held high
        for (int v = 0; v < 256; v++) begin
            wr(8'(v) | 8'h02);
            chk("R2 readback", bus_rdata, (8'(v) & 8'hC0) | 8'h03);
            chk("R4 oe", {7'b0, fb_oe}, {7'b0, v[7]});
        end
        chk("R7 no edge no irq", {7'b0, irq_n}, 8'h01);
        rd(8'h10, rv); chk("R2 unmapped", rv, 8'h00);

        // R3 glitch sweep with enable 0, interrupt enable 1 (R4)
        wr(8'h42);
        for (int L = 1; L <= N + 1; L++) begin
            logic seen, iseen;
            seen = 1'b0; iseen = 1'b0;
            @(negedge clk); sd_pin = 1'b0;
            for (int i = 0; i < L + N + 4; i++) begin
                @(posedge clk); #1;
                if (!bus_rdata[0]) seen = 1'b1;
                if (!irq_n) iseen = 1'b1;
                @(negedge clk);
                if (i == L - 1) sd_pin = 1'b1;
            end
            chk("R3 glitch", {7'b0, seen}, {7'b0, (L >= N)});
            chk("R4 no irq when off", {7'b0, iseen}, 8'h00);
        end

        // R3/R5/R7 latency of signal loss
        wr(8'hC2);
        idle(N + 3);
        chk("R5 fb high before", {7'b0, fb_out}, 8'h01);
        @(negedge clk); sd_pin = 1'b0;
        for (int k = 1; k <= N + 3; k++) begin
            @(posedge clk); #1;
            if (k == N + 1) chk("R3 sd still 1", {7'b0, bus_rdata[0]}, 8'h01);
            if (k == N + 2) begin
                chk("R3 sd now 0", {7'b0, bus_rdata[0]}, 8'h00);
                chk("R5 fb not yet", {7'b0, fb_out}, 8'h01);
                chk("R7 irq not yet", {7'b0, irq_n}, 8'h01);
            end
            if (k == N + 3) begin
                chk("R5 fb cleared", {7'b0, fb_out}, 8'h00);
                chk("R7 irq low", {7'b0, irq_n}, 8'h00);
            end
        end
        idle(5);
        chk("R8 irq held", {7'b0, irq_n}, 8'h00);
        rd(SA, rv); chk("R7 src code", rv, 8'h2E);
        chk("R8 irq cleared", {7'b0, irq_n}, 8'h01);
        rd(SA, rv); chk("R8 src cleared", rv, 8'h00);

        // R6 set ignored while signal lost
        wr(8'hC2);
        chk("R6 set ignored", {7'b0, fb_out}, 8'h00);
        idle(2);
        chk("R6 still clear", {7'b0, fb_out}, 8'h00);
        @(negedge clk); sd_pin = 1'b1;
        idle(N + 3);
        chk("R7 rise irq", {7'b0, irq_n}, 8'h00);
        rd(SA, rv); chk("R7 rise src", rv, 8'h2E);
        wr(8'hC2);
        chk("R6 set accepted", {7'b0, fb_out}, 8'h01);
        wr(8'hC0);
        chk("R6 clear accepted", {7'b0, fb_out}, 8'h00);

        // R1/R4 strapped default when disabled
        wr(8'h02);
        chk("R4 oe off", {7'b0, fb_oe}, 8'h00);
        @(negedge clk); strap = 1'b0;
        idle(N + 3);
        chk("R1 strap low", bus_rdata, 8'h01);
        chk("R8 irq idle", {7'b0, irq_n}, 8'h01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule